// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Fetcher

This block is the control half of one DMA channel. Software programs the address of the first descriptor in a chain and sets the run bit. The channel reads a six-word descriptor through a single-outstanding word-read master port. It splits the packed configuration word into separate source and destination settings, then holds a transfer command toward a data mover until the mover reports completion. After that it either fetches the next descriptor in the chain or, on the end-of-chain marker, stops and clears its run bit. Every completed descriptor produces a one-cycle completion event.

Software reaches the block through an eight-register window. There is a write port and a separate combinational read port, both addressed by the byte offset inside the channel window. Moving the data and arbitrating the bus belong to the mover and are not part of this block. A pause bit freezes the channel between steps without losing its place in the chain.

Top module: `dma_desc_chan`

## Requirements
- R1: After reset the channel is idle: `mem_req`, `cmd_valid` and `pkg_end` are low, and every register in the window reads 0.
- R2: Writing 1 to bit 0 of the run register (offset 0x00) while idle starts a fetch at the start address (offset 0x08, whose bits 1:0 always read as 0). The fetch makes six word reads at that address plus 0, 4, 8, 12, 16 and 20, which carry config, source, destination, byte count, parameter and next pointer, in that order.
- R3: Once the sixth word is in, `cmd_valid` rises with source, destination and byte count taken from the descriptor. The destination fields come from config bits 26:25 (width), 23:22 (burst), 21 (fixed address) and 20:16 (request line). The source fields come from bits 10:9, 7:6, 5 and 4:0. The wait count comes from parameter bits 7:0. Width code w gives 2^w bytes (1, 2, 4, 8), and burst code b gives 1, 4, 8 or 16 beats for b = 0..3.
- R4: `cmd_valid` stays high until `mover_done` is sampled high. `pkg_end` is then high for exactly one cycle, starting at the same clock edge at which `cmd_valid` falls.
- R5: A next pointer other than the end marker makes the channel fetch the next descriptor starting at that pointer.
- R6: A next pointer equal to 0xFFFFF800 ends the chain. After the final `mover_done` the run bit reads 0, the channel is idle, and no further reads are issued.
- R7: Writing 0 to the run bit stops the channel at the next edge: `cmd_valid` and `mem_req` drop, and no `pkg_end` is produced for the abandoned descriptor.
- R8: While the pause bit (offset 0x04, bit 0) is 1, no new memory read is raised and no new command is issued. The channel resumes where it stopped once the bit is cleared.
- R9: Offsets 0x0C, 0x10, 0x14, 0x18 and 0x1C read the config word, current source, current destination, bytes left and parameter word of the descriptor in flight, and writes to them are ignored. Bytes left reads 0 once the descriptor completes.
- R10: A memory read holds `mem_req` and a word-aligned `mem_addr` unchanged until `mem_ack`. A `mem_ack` with no request pending, and a `mover_done` with no command pending, have no effect.
- R11: Writing 1 to the run bit while the channel is busy does not restart it or cause any additional reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 6 | Write byte offset within the channel window |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 6 | Read byte offset within the channel window |
| reg_rdata | output | 32 | Read data (combinational) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_ack | input | 1 | Read completion, qualifies mem_rdata |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Transfer command pending at the mover |
| cmd_src | output | 32 | Source address |
| cmd_dst | output | 32 | Destination address |
| cmd_bytes | output | 32 | Byte count |
| cmd_src_wcode | output | 2 | Source width code |
| cmd_dst_wcode | output | 2 | Destination width code |
| cmd_src_size | output | 4 | Source beat size in bytes |
| cmd_dst_size | output | 4 | Destination beat size in bytes |
| cmd_src_beats | output | 5 | Source burst length in beats |
| cmd_dst_beats | output | 5 | Destination burst length in beats |
| cmd_src_fixed | output | 1 | Source address held fixed |
| cmd_dst_fixed | output | 1 | Destination address held fixed |
| cmd_src_req | output | 5 | Source request line |
| cmd_dst_req | output | 5 | Destination request line |
| cmd_wait | output | 8 | Wait cycles between beats |
| mover_done | input | 1 | Mover finished the pending command |
| pkg_end | output | 1 | One-cycle descriptor completion event |

## Verification
The bench uses the default end marker 0xFFFFF800 and places descriptors at low word addresses. A one-link chain and a two-link chain therefore both terminate naturally, and the fetch order, the chain hop and the run-bit self-clear are all observed. The memory responder answers every request one cycle after seeing it. This makes the per-word fetch timing deterministic, so pause and a busy re-enable can be applied in a known state. Halting during a live command and issuing stray completions while idle cover the abort and ignore paths.

// File: rtl/dma_desc_chan.sv
module dma_desc_chan #(
  parameter logic [31:0] END_PTR = 32'hFFFF_F800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [5:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [5:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        cmd_valid,
  output logic [31:0] cmd_src,
  output logic [31:0] cmd_dst,
  output logic [31:0] cmd_bytes,
  output logic [1:0]  cmd_src_wcode,
  output logic [1:0]  cmd_dst_wcode,
  output logic [3:0]  cmd_src_size,
  output logic [3:0]  cmd_dst_size,
  output logic [4:0]  cmd_src_beats,
  output logic [4:0]  cmd_dst_beats,
  output logic        cmd_src_fixed,
  output logic        cmd_dst_fixed,
  output logic [4:0]  cmd_src_req,
  output logic [4:0]  cmd_dst_req,
  output logic [7:0]  cmd_wait,
  input  logic        mover_done,
  output logic        pkg_end
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_LAUNCH, S_EXEC} state_t;

  state_t      state_q;
  logic        run_q, pause_q, req_q, pkg_q;
  logic [31:0] start_q, ptr_q, cfg_q, src_q, dst_q, cnt_q, para_q, next_q;
  logic [2:0]  idx_q;

  logic run_wr, start, halt, last_word, chain_end;

  assign run_wr    = reg_we && (reg_waddr == 6'h00);
  assign start     = run_wr && reg_wdata[0] && (state_q == S_IDLE);
  assign halt      = run_wr && !reg_wdata[0];
  assign last_word = (idx_q == 3'd5);
  assign chain_end = (next_q == END_PTR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      run_q   <= 1'b0;
      pause_q <= 1'b0;
      req_q   <= 1'b0;
      pkg_q   <= 1'b0;
      start_q <= '0;
      ptr_q   <= '0;
      idx_q   <= '0;
      cfg_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      para_q  <= '0;
      next_q  <= '0;
    end else begin
      pkg_q <= 1'b0;
      if (reg_we && reg_waddr == 6'h04) pause_q <= reg_wdata[0];
      if (reg_we && reg_waddr == 6'h08) start_q <= reg_wdata & 32'hFFFF_FFFC;
      if (halt) begin
        state_q <= S_IDLE;
        run_q   <= 1'b0;
        req_q   <= 1'b0;
      end else begin
        case (state_q)
          S_IDLE: if (start) begin
            run_q   <= 1'b1;
            ptr_q   <= start_q;
            idx_q   <= '0;
            state_q <= S_FETCH;
          end
          S_FETCH: begin
            if (!req_q && !pause_q) req_q <= 1'b1;
            if (req_q && mem_ack) begin
              req_q <= 1'b0;
              case (idx_q)
                3'd0:    cfg_q  <= mem_rdata;
                3'd1:    src_q  <= mem_rdata;
                3'd2:    dst_q  <= mem_rdata;
                3'd3:    cnt_q  <= mem_rdata;
                3'd4:    para_q <= mem_rdata;
                default: next_q <= mem_rdata;
              endcase
              if (last_word) state_q <= S_LAUNCH;
              else           idx_q   <= idx_q + 3'd1;
            end
          end
          S_LAUNCH: if (!pause_q) state_q <= S_EXEC;
          S_EXEC: if (mover_done) begin
            pkg_q <= 1'b1;
            cnt_q <= '0;
            if (chain_end) begin
              state_q <= S_IDLE;
              run_q   <= 1'b0;
            end else begin
              ptr_q   <= next_q & 32'hFFFF_FFFC;
              idx_q   <= '0;
              state_q <= S_FETCH;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign mem_req   = req_q;
  assign mem_addr  = ptr_q + {27'd0, idx_q, 2'b00};
  assign cmd_valid = (state_q == S_EXEC);
  assign pkg_end   = pkg_q;

  assign cmd_src       = src_q;
  assign cmd_dst       = dst_q;
  assign cmd_bytes     = cnt_q;
  assign cmd_dst_wcode = cfg_q[26:25];
  assign cmd_src_wcode = cfg_q[10:9];
  assign cmd_dst_size  = 4'd1 << cfg_q[26:25];
  assign cmd_src_size  = 4'd1 << cfg_q[10:9];
  assign cmd_dst_beats = (cfg_q[23:22] == 2'd0) ? 5'd1 : (5'd2 << cfg_q[23:22]);
  assign cmd_src_beats = (cfg_q[7:6] == 2'd0) ? 5'd1 : (5'd2 << cfg_q[7:6]);
  assign cmd_dst_fixed = cfg_q[21];
  assign cmd_src_fixed = cfg_q[5];
  assign cmd_dst_req   = cfg_q[20:16];
  assign cmd_src_req   = cfg_q[4:0];
  assign cmd_wait      = para_q[7:0];

  always_comb begin
    case (reg_raddr)
      6'h00:   reg_rdata = {31'd0, run_q};
      6'h04:   reg_rdata = {31'd0, pause_q};
      6'h08:   reg_rdata = start_q;
      6'h0C:   reg_rdata = cfg_q;
      6'h10:   reg_rdata = src_q;
      6'h14:   reg_rdata = dst_q;
      6'h18:   reg_rdata = cnt_q;
      6'h1C:   reg_rdata = para_q;
      default: reg_rdata = '0;
    endcase
  end

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !halt) |=> (mem_req && $stable(mem_addr)));
  a_r10_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  a_r8_no_req_when_paused: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> !$past(pause_q));
  a_r8_no_cmd_when_paused: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> !$past(pause_q));
  a_r4_event_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    pkg_end |-> $past(cmd_valid && mover_done));
  a_r4_single_cycle_event: assert property (@(posedge clk) disable iff (!rst_n)
    pkg_end |=> !pkg_end);
  a_r7_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!cmd_valid && !mem_req && !pkg_end));
  a_r3_read_or_command: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && cmd_valid));
  a_r6_idle_not_running: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> !run_q);

endmodule

// File: tb/dma_desc_chan_tb_top.sv
`timescale 1ns/1ps
module dma_desc_chan_tb_top;
  localparam logic [31:0] ENDP = 32'hFFFF_F800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [5:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        cmd_valid;
  logic [31:0] cmd_src, cmd_dst, cmd_bytes;
  logic [1:0]  cmd_src_wcode, cmd_dst_wcode;
  logic [3:0]  cmd_src_size, cmd_dst_size;
  logic [4:0]  cmd_src_beats, cmd_dst_beats;
  logic        cmd_src_fixed, cmd_dst_fixed;
  logic [4:0]  cmd_src_req, cmd_dst_req;
  logic [7:0]  cmd_wait;
  logic        mover_done = 1'b0;
  logic        pkg_end;

  int checks = 0;
  int errors = 0;
  int nlog = 0;
  int npkg = 0;
  logic [31:0] mem_arr [0:63];
  logic [31:0] flog [0:63];
  logic force_ack = 1'b0;

  always #2 clk = ~clk;

  dma_desc_chan dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_bytes(cmd_bytes),
    .cmd_src_wcode(cmd_src_wcode), .cmd_dst_wcode(cmd_dst_wcode),
    .cmd_src_size(cmd_src_size), .cmd_dst_size(cmd_dst_size),
    .cmd_src_beats(cmd_src_beats), .cmd_dst_beats(cmd_dst_beats),
    .cmd_src_fixed(cmd_src_fixed), .cmd_dst_fixed(cmd_dst_fixed),
    .cmd_src_req(cmd_src_req), .cmd_dst_req(cmd_dst_req), .cmd_wait(cmd_wait),
    .mover_done(mover_done), .pkg_end(pkg_end)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (force_ack) begin
        mem_rdata = 32'hDEAD_BEEF;
        mem_ack = 1'b1;
      end else if (mem_req) begin
        mem_rdata = mem_arr[mem_addr[7:2]];
        if (nlog < 64) flog[nlog] = mem_addr;
        nlog++;
        mem_ack = 1'b1;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (pkg_end) npkg++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_cmd();
    int n = 0;
    while (!cmd_valid && n < 300) begin @(negedge clk); n++; end
  endtask

  task automatic done_pulse();
    @(negedge clk);
    mover_done = 1'b1;
    @(negedge clk);
    mover_done = 1'b0;
  endtask

  function automatic logic [31:0] mkcfg(int dw, int db, int df, int dr, int sw, int sb, int sf, int sr);
    return (32'(dw) << 25) | (32'(db) << 22) | (32'(df) << 21) | (32'(dr) << 16) |
           (32'(sw) << 9) | (32'(sb) << 6) | (32'(sf) << 5) | 32'(sr);
  endfunction

  task automatic put_desc(int w, logic [31:0] c, logic [31:0] s, logic [31:0] d,
                          logic [31:0] n, logic [31:0] p, logic [31:0] nx);
    mem_arr[w] = c; mem_arr[w+1] = s; mem_arr[w+2] = d;
    mem_arr[w+3] = n; mem_arr[w+4] = p; mem_arr[w+5] = nx;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 cmd_valid", 32'(cmd_valid), 0);
    chk("R1 pkg_end", 32'(pkg_end), 0);
    for (int a = 0; a < 8; a++) begin
      rd(6'(a * 4), v);
      chk("R1 register", v, 0);
    end
  endtask

  task automatic t_single();
    logic [31:0] v;
    int base;
    put_desc(16, mkcfg(3, 2, 1, 17, 1, 3, 0, 5), 32'h1000_0000, 32'h2000_0040,
             32'd256, 32'hABCD_1237, ENDP);
    wr(6'h08, 32'h0000_0041);
    rd(6'h08, v);
    chk("R2 start addr aligned", v, 32'h40);
    base = nlog;
    wr(6'h00, 32'h1);
    wait_cmd();
    chk("R3 cmd_valid", 32'(cmd_valid), 1);
    chk("R2 read count", 32'(nlog - base), 6);
    for (int i = 0; i < 6; i++) chk("R2 read order", flog[base + i], 32'(32'h40 + 4 * i));
    chk("R3 src", cmd_src, 32'h1000_0000);
    chk("R3 dst", cmd_dst, 32'h2000_0040);
    chk("R3 bytes", cmd_bytes, 256);
    chk("R3 dst wcode", 32'(cmd_dst_wcode), 3);
    chk("R3 dst size", 32'(cmd_dst_size), 8);
    chk("R3 dst beats", 32'(cmd_dst_beats), 8);
    chk("R3 dst fixed", 32'(cmd_dst_fixed), 1);
    chk("R3 dst req", 32'(cmd_dst_req), 17);
    chk("R3 src wcode", 32'(cmd_src_wcode), 1);
    chk("R3 src size", 32'(cmd_src_size), 2);
    chk("R3 src beats", 32'(cmd_src_beats), 16);
    chk("R3 src fixed", 32'(cmd_src_fixed), 0);
    chk("R3 src req", 32'(cmd_src_req), 5);
    chk("R3 wait", 32'(cmd_wait), 32'h37);
    rd(6'h10, v); chk("R9 cur src", v, 32'h1000_0000);
    rd(6'h14, v); chk("R9 cur dst", v, 32'h2000_0040);
    rd(6'h18, v); chk("R9 bytes left", v, 256);
    rd(6'h0C, v); chk("R9 config", v, mkcfg(3, 2, 1, 17, 1, 3, 0, 5));
    rd(6'h1C, v); chk("R9 param", v, 32'hABCD_1237);
    wr(6'h10, 32'h5555_5555);
    rd(6'h10, v); chk("R9 write ignored", v, 32'h1000_0000);
    wr(6'h00, 32'h1);
    cycles(3);
    chk("R11 no restart reads", 32'(nlog - base), 6);
    chk("R11 still commanding", 32'(cmd_valid), 1);
    chk("R4 held until done", 32'(npkg), 0);
    @(negedge clk);
    mover_done = 1'b1;
    @(negedge clk);
    mover_done = 1'b0;
    chk("R4 cmd drops", 32'(cmd_valid), 0);
    chk("R4 pkg_end high", 32'(pkg_end), 1);
    @(negedge clk);
    chk("R4 pkg_end one cycle", 32'(pkg_end), 0);
    rd(6'h00, v); chk("R6 run cleared", v, 0);
    rd(6'h18, v); chk("R9 bytes left zero", v, 0);
    cycles(10);
    chk("R6 no further reads", 32'(nlog - base), 6);
    chk("R6 one event", 32'(npkg), 1);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    int base, p0;
    put_desc(16, mkcfg(0, 0, 0, 0, 0, 0, 0, 0), 32'hA, 32'hB, 32'd4, 32'h0, 32'h80);
    put_desc(32, mkcfg(0, 1, 0, 0, 2, 0, 1, 31), 32'h3000_0000, 32'h4000_0000,
             32'd64, 32'h0000_0009, ENDP);
    wr(6'h08, 32'h40);
    base = nlog; p0 = npkg;
    wr(6'h00, 32'h1);
    wait_cmd();
    cycles(5);
    chk("R4 held without done", 32'(cmd_valid), 1);
    done_pulse();
    wait_cmd();
    chk("R5 hop read count", 32'(nlog - base), 12);
    for (int i = 0; i < 6; i++) chk("R5 hop read order", flog[base + 6 + i], 32'(32'h80 + 4 * i));
    chk("R5 src", cmd_src, 32'h3000_0000);
    chk("R5 bytes", cmd_bytes, 64);
    chk("R3 src size 4", 32'(cmd_src_size), 4);
    chk("R3 src beats 1", 32'(cmd_src_beats), 1);
    chk("R3 dst beats 4", 32'(cmd_dst_beats), 4);
    chk("R3 dst size 1", 32'(cmd_dst_size), 1);
    chk("R3 src req 31", 32'(cmd_src_req), 31);
    chk("R3 src fixed", 32'(cmd_src_fixed), 1);
    rd(6'h00, v); chk("R5 still running", v, 1);
    done_pulse();
    cycles(5);
    chk("R6 two events", 32'(npkg - p0), 2);
    rd(6'h00, v); chk("R6 run cleared after chain", v, 0);
    chk("R6 no reads after chain", 32'(nlog - base), 12);
  endtask

  task automatic t_halt();
    logic [31:0] v;
    int p0;
    wr(6'h08, 32'h40);
    p0 = npkg;
    wr(6'h00, 32'h1);
    wait_cmd();
    wr(6'h00, 32'h0);
    chk("R7 cmd dropped", 32'(cmd_valid), 0);
    chk("R7 no read", 32'(mem_req), 0);
    done_pulse();
    cycles(3);
    chk("R7 no event", 32'(npkg - p0), 0);
    rd(6'h00, v); chk("R7 run reads 0", v, 0);
  endtask

  task automatic t_pause();
    int base, p0;
    put_desc(16, mkcfg(2, 0, 0, 0, 2, 0, 0, 0), 32'h11, 32'h22, 32'd8, 32'h0, 32'h80);
    put_desc(32, mkcfg(2, 0, 0, 0, 2, 0, 0, 0), 32'h33, 32'h44, 32'd8, 32'h0, ENDP);
    wr(6'h04, 32'h1);
    wr(6'h08, 32'h40);
    base = nlog; p0 = npkg;
    wr(6'h00, 32'h1);
    cycles(20);
    chk("R8 no read while paused", 32'(nlog - base), 0);
    chk("R8 no command while paused", 32'(cmd_valid), 0);
    wr(6'h04, 32'h0);
    wait_cmd();
    chk("R8 resumed command", cmd_src, 32'h11);
    wr(6'h04, 32'h1);
    done_pulse();
    cycles(20);
    chk("R8 event while paused", 32'(npkg - p0), 1);
    chk("R8 no hop read while paused", 32'(nlog - base), 6);
    wr(6'h04, 32'h0);
    wait_cmd();
    chk("R8 resumed hop", cmd_src, 32'h33);
    done_pulse();
    cycles(3);
    chk("R8 chain finished", 32'(npkg - p0), 2);
  endtask

  task automatic t_stray();
    logic [31:0] v, c0;
    int p0;
    rd(6'h0C, c0);
    p0 = npkg;
    @(negedge clk); force_ack = 1'b1;
    @(negedge clk); force_ack = 1'b0;
    cycles(2);
    rd(6'h0C, v); chk("R10 stray ack ignored", v, c0);
    chk("R10 no request", 32'(mem_req), 0);
    done_pulse();
    cycles(2);
    chk("R10 stray done ignored", 32'(npkg - p0), 0);
    chk("R10 no command", 32'(cmd_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem_arr[i] = '0;
    cycles(3);
    t_reset();
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_single();
    t_chain();
    t_halt();
    t_pause();
    t_stray();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule